// File: doc/BRIEF.md
# PWM ADC Trigger Event Generator

This block turns the compare-match strobes of a PWM time base into two ADC start-of-conversion pulses. Three single-cycle compare strobes (A, B and C) arrive on one bus. Each trigger output has its own mask that picks which of the three strobes it responds to.

The second trigger is the plain OR of its enabled strobes. The first trigger is shaped further. It first throws away a programmable number of qualifying events, and from then on it fires on only one event in every N.

Configuration is written through a two-register port with a write enable and a one-bit address. Both trigger outputs are registered single-cycle pulses.

Top module: `pwm_adc_trig_gen`

## Requirements
- R1: Trigger 1 counts a qualified event in any cycle where a strobe fires and its mask bit is set. The mask is register 0 bits [2:0]: bit 0 selects A, bit 1 selects B, bit 2 selects C. On `cmp_evt`, bit 0 is A, bit 1 is B and bit 2 is C.
- R2: Trigger 2 pulses for every cycle in which any strobe enabled by register 0 bits [5:3] fires (same A/B/C order). It is never offset or divided.
- R3: Register 1 bits [4:0] hold a postscale value n. After the offset, trigger 1 fires on every (n+1)-th qualified event, so 0 gives 1:1 and 31 gives 1:32.
- R4: Register 1 bits [9:5] hold an offset value m. The first m qualified events after reset or after a write to register 1 are discarded. The offset applies once, and postscale counting starts with the next event.
- R5: After reset every field is zero, so neither trigger fires whatever the strobes do.
- R6: A write to register 1 clears the offset and postscale counters. A qualified event in that same cycle is dropped.
- R7: Several enabled strobes in one cycle count as a single qualified event.
- R8: A trigger output goes high for exactly one clock, in the cycle after the strobe that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 1 | Register select: 0 = masks, 1 = offset/postscale |
| cfg_wdata | input | 10 | Configuration write data |
| cmp_evt | input | 3 | Compare strobes, bit 0 = A, bit 1 = B, bit 2 = C |
| trig1_o | output | 1 | Offset and postscaled ADC trigger 1 pulse |
| trig2_o | output | 1 | Unscaled ADC trigger 2 pulse |

## Verification
The hardest states to reach are the far ends of the counters. One is a 1:32 postscale or a 31-event offset, where the first pulse appears only on the 32nd qualified event. The other is a reconfiguration that lands while a count is partly done.

The bench gets there by sending long runs of strobes and counting the trigger pulses at the ports. For the reconfiguration case, it writes register 1 again with the same value partway through a count and then checks that the full count restarts from zero.

// File: rtl/pwm_adc_trig_gen.sv
module pwm_adc_trig_gen #(
  parameter int SRC_N = 3,
  parameter int CNT_W = 5,
  localparam int DATA_W = 2 * CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [SRC_N-1:0]  cmp_evt,
  output logic              trig1_o,
  output logic              trig2_o
);

  logic [SRC_N-1:0] en1_q, en2_q;
  logic [CNT_W-1:0] ofs_q, ps_q, ofs_cnt, ps_cnt;

  wire wr_mask  = cfg_we && !cfg_addr;
  wire wr_tim   = cfg_we && cfg_addr;
  wire hit1     = |(cmp_evt & en1_q);
  wire hit2     = |(cmp_evt & en2_q);
  wire ofs_done = (ofs_cnt == ofs_q);
  wire ps_wrap  = (ps_cnt == ps_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en1_q   <= '0;
      en2_q   <= '0;
      ofs_q   <= '0;
      ps_q    <= '0;
      ofs_cnt <= '0;
      ps_cnt  <= '0;
      trig1_o <= 1'b0;
      trig2_o <= 1'b0;
    end else begin
      trig2_o <= hit2;
      trig1_o <= 1'b0;
      if (wr_mask) begin
        en1_q <= cfg_wdata[SRC_N-1:0];
        en2_q <= cfg_wdata[2*SRC_N-1:SRC_N];
      end
      if (wr_tim) begin
        ps_q    <= cfg_wdata[CNT_W-1:0];
        ofs_q   <= cfg_wdata[2*CNT_W-1:CNT_W];
        ofs_cnt <= '0;
        ps_cnt  <= '0;
      end else if (hit1) begin
        if (!ofs_done) begin
          ofs_cnt <= ofs_cnt + CNT_W'(1);
        end else if (ps_wrap) begin
          ps_cnt  <= '0;
          trig1_o <= 1'b1;
        end else begin
          ps_cnt <= ps_cnt + CNT_W'(1);
        end
      end
    end
  end

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_evt == '0) |=> (!trig1_o && !trig2_o)); // R8
  AST_T1_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (en1_q == '0) |=> !trig1_o); // R1
  AST_T2_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (en2_q == '0) |=> !trig2_o); // R2
  AST_PS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ps_cnt <= ps_q); // R3
  AST_OFS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_cnt <= ofs_q); // R4
  AST_CFG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tim |=> (ofs_cnt == '0 && ps_cnt == '0 && !trig1_o)); // R6

endmodule

// File: tb/pwm_adc_trig_gen_tb.sv
module pwm_adc_trig_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic       cfg_addr = 1'b0;
  logic [9:0] cfg_wdata = '0;
  logic [2:0] cmp_evt = '0;
  logic       trig1_o, trig2_o;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pwm_adc_trig_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cmp_evt(cmp_evt), .trig1_o(trig1_o), .trig2_o(trig2_o)
  );

  // {cmp[2:0], exp_trig1, exp_trig2}; masks t1=A|B, t2=C, offset 2, postscale 1
  localparam logic [4:0] VEC [12] = '{
    5'b001_0_0, 5'b100_0_1, 5'b011_0_0, 5'b000_0_0,
    5'b010_0_0, 5'b111_1_1, 5'b001_0_0, 5'b001_1_0,
    5'b100_0_1, 5'b000_0_0, 5'b010_0_0, 5'b110_1_1
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input logic a, input logic [9:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input logic [2:0] c, output logic t1, output logic t2);
    @(negedge clk);
    cmp_evt = c;
    @(negedge clk);
    cmp_evt = '0;
    t1 = trig1_o;
    t2 = trig2_o;
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic t1, t2;
    int fires;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R5 reset trig1", trig1_o, 0);
    check("R5 reset trig2", trig2_o, 0);
    pulse(3'b111, t1, t2);
    check("R5 disabled trig1", t1, 0);
    check("R5 disabled trig2", t2, 0);

    // R1 R2 R3 R4 R7 table walk
    cfg(1'b0, {4'b0, 3'b100, 3'b011});
    cfg(1'b1, {5'd2, 5'd1});
    for (int i = 0; i < 12; i++) begin
      pulse(VEC[i][4:2], t1, t2);
      check($sformatf("R1/R7 vec%0d trig1", i), t1, VEC[i][1]);
      check($sformatf("R2 vec%0d trig2", i), t2, VEC[i][0]);
    end

    // R3 1:1 and R8 single-cycle pulse
    cfg(1'b0, {4'b0, 3'b000, 3'b001});
    cfg(1'b1, {5'd0, 5'd0});
    for (int i = 0; i < 3; i++) begin
      pulse(3'b001, t1, t2);
      check("R3 ratio 1:1", t1, 1);
    end
    @(negedge clk);
    check("R8 pulse width", trig1_o, 0);
    pulse(3'b110, t1, t2);
    check("R1 unmasked source", t1, 0);

    // R3 1:32
    cfg(1'b1, {5'd0, 5'd31});
    fires = 0;
    for (int i = 0; i < 31; i++) begin
      pulse(3'b001, t1, t2);
      fires += int'(t1);
    end
    check("R3 1:32 early fires", fires, 0);
    pulse(3'b001, t1, t2);
    check("R3 1:32 event 32", t1, 1);

    // R4 offset 31, applied once
    cfg(1'b1, {5'd31, 5'd0});
    fires = 0;
    for (int i = 0; i < 31; i++) begin
      pulse(3'b001, t1, t2);
      fires += int'(t1);
    end
    check("R4 offset 31 discarded", fires, 0);
    pulse(3'b001, t1, t2);
    check("R4 event 32", t1, 1);
    pulse(3'b001, t1, t2);
    check("R4 offset once", t1, 1);

    // R6 rewrite clears partial count
    cfg(1'b1, {5'd0, 5'd2});
    pulse(3'b001, t1, t2);
    pulse(3'b001, t1, t2);
    cfg(1'b1, {5'd0, 5'd2});
    fires = 0;
    for (int i = 0; i < 2; i++) begin
      pulse(3'b001, t1, t2);
      fires += int'(t1);
    end
    check("R6 restart no early fire", fires, 0);
    pulse(3'b001, t1, t2);
    check("R6 restart third event", t1, 1);

    // R6 event in write cycle dropped
    cfg(1'b1, {5'd0, 5'd0});
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 1'b1; cfg_wdata = {5'd0, 5'd0}; cmp_evt = 3'b001;
    @(negedge clk);
    cfg_we = 1'b0; cmp_evt = '0;
    check("R6 write-cycle event dropped", trig1_o, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule